// File: doc/BRIEF.md
# Dual-Path Edge Timestamp Recorder

The block timestamps rising edges of one square-wave input and keeps the stamps on two paths at once. A free-running timebase counts down once per `tick_en` strobe. In the target system that strobe comes at 32768 Hz. On every qualified rising edge the direct path copies the timebase value into its own circular buffer. The prescaled path counts the same edges and copies the timebase only on every `PRESCALE`-th edge.

Each buffer holds `DEPTH` stamps, six by default. A reader selects a path and sees the newest stamp, the stamp before it, the stored-entry count, a valid flag and the period in timebase ticks. Because the timebase counts down, the period is the older stamp minus the newer one.

The direct path suits slow inputs, from about 1 Hz up to about 150 Hz. The prescaled path keeps its resolution from about 150 Hz up to 5 kHz, so the counter does not need to be wider. A range output tells software which path to trust. It selects the prescaled path when the direct period is shorter than `RANGE_TICKS`, which defaults to 218, the tick count of one 150 Hz period.

**Edge recogniser states.** `EDGE_WAIT` is the state after reset; it moves to `EDGE_HIGH` or `EDGE_LOW` from the synchronised level and emits no pulse. `EDGE_LOW` moves to `EDGE_HIGH` on a high level and emits one capture pulse. `EDGE_HIGH` moves to `EDGE_LOW` on a low level and emits no pulse.

**Ring fill states.** `FILL_EMPTY` moves to `FILL_ONE` on a write. `FILL_ONE` moves to `FILL_MULTI` on a write. `FILL_MULTI` holds. A clear sends every state to `FILL_EMPTY`.

Top module: `edge_stamp_dual`

## Requirements
- R1: On a rising edge of `sig_in` the direct path stores the timebase value as its newest stamp. While `tick_en` stays low, that stamp is visible at the read port by the fourth clock edge after the edge is applied.
- R2: The timebase resets to all ones. It decrements by one on each clock edge that sees `tick_en` high, holds otherwise, and wraps from zero to all ones.
- R3: Each ring holds `DEPTH` (6) stamps, and its write pointer wraps to slot 0 after the last slot. Newest and previous stamps stay correct across the wrap. `rd_count` counts stored stamps and saturates at `DEPTH`.
- R4: `rd_period` equals previous stamp minus newest stamp, modulo 2^`CNT_W`. It reads 0 while `rd_valid` is low.
- R5: `rd_valid` is high exactly when the selected ring holds at least two stamps.
- R6: The prescaled path stores a stamp only on every `PRESCALE`-th rising edge, counted from reset or clear. The intervening edges leave its ring unchanged.
- R7: When both paths capture on the same edge, they store the same timebase value.
- R8: `use_prescaled` is 1 exactly when the direct path is valid and its period is below `RANGE_TICKS`.
- R9: A one-cycle `clr` empties both rings and restarts the prescaler edge count. The valid flags drop, and the timebase is left untouched.
- R10: A level that is already high at reset, a high level held over many cycles, and falling edges produce no stamp. A held high level yields one stamp for its rising edge only.
- R11: `rd_path` = 0 selects the direct path and `rd_path` = 1 selects the prescaled path for all read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase decrement strobe |
| sig_in | input | 1 | Asynchronous square-wave input |
| clr | input | 1 | Synchronous clear of both rings and the prescaler |
| rd_path | input | 1 | Path select: 0 direct, 1 prescaled |
| rd_newest | output | CNT_W | Newest stamp of the selected path |
| rd_older | output | CNT_W | Stamp before the newest |
| rd_period | output | CNT_W | Previous minus newest stamp, 0 when not valid |
| rd_count | output | $clog2(DEPTH+1) | Stored stamps, saturating at DEPTH |
| rd_valid | output | 1 | At least two stamps stored |
| use_prescaled | output | 1 | Direct period below RANGE_TICKS |

## Verification
The bench runs with an 8-bit timebase and a prescaler of 4. The first sweep steps edge spacings through the 200 to 229 tick band, crossing the 218-tick threshold one tick at a time and wrapping the counter repeatedly. This separates a strict from an inclusive comparison and a correct from a wrong-direction subtraction. A second sweep spaces edges from 0 to 264 ticks in steps of 11, which covers zero-length periods and spacings that alias past the counter width. Separate patterns check that a level high through reset is not stamped, that a long high level gives one stamp, and that after a clear the prescaler waits the full four edges, so a missed restart of its edge count shows up.

// File: rtl/esd_pkg.sv
`timescale 1ns/1ps
package esd_pkg;

    typedef enum logic [1:0] {
        EDGE_WAIT = 2'd0,
        EDGE_LOW  = 2'd1,
        EDGE_HIGH = 2'd2
    } edge_state_t;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_MULTI = 2'd2
    } fill_state_t;

    localparam int PATH_DIRECT    = 0;
    localparam int PATH_PRESCALED = 1;
    localparam int NUM_PATHS      = 2;

endpackage

// File: rtl/esd_timebase.sv
`timescale 1ns/1ps
module esd_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '1;
        end else if (tick_en) begin
            count <= count - CNT_W'(1);
        end
    end

    assert_tick_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == CNT_W'($past(count) - CNT_W'(1)));

    assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

endmodule

// File: rtl/esd_edge_fsm.sv
`timescale 1ns/1ps
module esd_edge_fsm
    import esd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);

    logic [1:0]  sync_q;
    edge_state_t state_q, state_d;

    // two-flop synchroniser, preset high so a level present at reset is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], sig_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EDGE_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_WAIT: state_d = sync_q[1] ? EDGE_HIGH : EDGE_LOW;
            EDGE_LOW:  if (sync_q[1])  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!sync_q[1]) state_d = EDGE_LOW;
            default:   state_d = EDGE_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise <= 1'b0;
        end else begin
            rise <= (state_q == EDGE_LOW) && sync_q[1];
        end
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    assert_pulse_from_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (state_q == EDGE_HIGH));

endmodule

// File: rtl/esd_prescaler.sv
`timescale 1ns/1ps
module esd_prescaler #(
    parameter int PRESCALE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rise,
    output logic strobe
);

    generate
        if (PRESCALE <= 1) begin : g_bypass
            assign strobe = rise;
        end else begin : g_count
            localparam int CW = $clog2(PRESCALE);
            localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

            logic [CW-1:0] edge_cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    edge_cnt <= '0;
                end else if (rise) begin
                    edge_cnt <= (edge_cnt == LAST) ? '0 : edge_cnt + CW'(1);
                end
            end

            assign strobe = rise && !clr && (edge_cnt == LAST);

            assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
                edge_cnt <= LAST);

            assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
                strobe |=> edge_cnt == '0);

            assert_clear_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> edge_cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/esd_ring.sv
`timescale 1ns/1ps
module esd_ring
    import esd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [CNT_W-1:0]           stamp,
    output logic [CNT_W-1:0]           newest,
    output logic [CNT_W-1:0]           older,
    output logic [CNT_W-1:0]           period,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       valid
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CNT_W-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    new_idx, old_idx;
    fill_state_t      state_q, state_d;
    logic             do_write;

    assign do_write = we && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else if (do_write) begin
            slots[wr_ptr] <= stamp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (do_write) begin
            wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + PW'(1);
            if (count != FULL_CNT) begin
                count <= count + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = FILL_EMPTY;
        end else begin
            unique case (state_q)
                FILL_EMPTY: if (we) state_d = FILL_ONE;
                FILL_ONE:   if (we) state_d = FILL_MULTI;
                FILL_MULTI: state_d = FILL_MULTI;
                default:    state_d = FILL_EMPTY;
            endcase
        end
    end

    always_comb begin
        new_idx = (wr_ptr == '0) ? LAST_IDX : wr_ptr - PW'(1);
        old_idx = (new_idx == '0) ? LAST_IDX : new_idx - PW'(1);
        newest  = slots[new_idx];
        older   = slots[old_idx];
        valid   = (state_q == FILL_MULTI);
        period  = valid ? (older - newest) : '0;
    end

    assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && wr_ptr == LAST_IDX) |=> wr_ptr == '0);

    assert_count_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_valid_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> count >= CW'(2));

    assert_stamp_stored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> newest == $past(stamp));

    assert_clear_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !valid));

endmodule

// File: rtl/edge_stamp_dual.sv
`timescale 1ns/1ps
module edge_stamp_dual
    import esd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DEPTH       = 6,
    parameter int PRESCALE    = 32,
    parameter int RANGE_TICKS = 218
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       sig_in,
    input  logic                       clr,
    input  logic                       rd_path,
    output logic [CNT_W-1:0]           rd_newest,
    output logic [CNT_W-1:0]           rd_older,
    output logic [CNT_W-1:0]           rd_period,
    output logic [$clog2(DEPTH+1)-1:0] rd_count,
    output logic                       rd_valid,
    output logic                       use_prescaled
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] RANGE_LIM = CNT_W'(RANGE_TICKS);

    logic [CNT_W-1:0] tb_count;
    logic             rise;
    logic             pre_strobe;
    logic             path_we     [NUM_PATHS];
    logic [CNT_W-1:0] path_newest [NUM_PATHS];
    logic [CNT_W-1:0] path_older  [NUM_PATHS];
    logic [CNT_W-1:0] path_period [NUM_PATHS];
    logic [CW-1:0]    path_count  [NUM_PATHS];
    logic             path_valid  [NUM_PATHS];

    esd_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .count   (tb_count)
    );

    esd_edge_fsm u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .rise   (rise)
    );

    esd_prescaler #(.PRESCALE(PRESCALE)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .rise   (rise),
        .strobe (pre_strobe)
    );

    assign path_we[PATH_DIRECT]    = rise;
    assign path_we[PATH_PRESCALED] = pre_strobe;

    generate
        for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
            esd_ring #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_ring (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr),
                .we     (path_we[g]),
                .stamp  (tb_count),
                .newest (path_newest[g]),
                .older  (path_older[g]),
                .period (path_period[g]),
                .count  (path_count[g]),
                .valid  (path_valid[g])
            );
        end
    endgenerate

    always_comb begin
        rd_newest     = path_newest[rd_path];
        rd_older      = path_older[rd_path];
        rd_period     = path_period[rd_path];
        rd_count      = path_count[rd_path];
        rd_valid      = path_valid[rd_path];
        use_prescaled = path_valid[PATH_DIRECT] && (path_period[PATH_DIRECT] < RANGE_LIM);
    end

    assert_same_stamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_strobe && !clr) |=> path_newest[PATH_PRESCALED] == path_newest[PATH_DIRECT]);

    assert_prescaled_only_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_strobe |-> rise);

endmodule

// File: tb/edge_stamp_dual_bench.sv
`timescale 1ns/1ps
module edge_stamp_dual_bench;

    localparam int W   = 8;
    localparam int DEP = 6;
    localparam int PS  = 4;
    localparam int RNG = 218;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         sig_in = 1'b1;
    logic         clr = 1'b0;
    logic         rd_path = 1'b0;
    logic [W-1:0] rd_newest, rd_older, rd_period;
    logic [2:0]   rd_count;
    logic         rd_valid, use_prescaled;

    int checks = 0;
    int errors = 0;
    int ticks = 0;
    int pre_edges = 0;
    int exp_cnt [2];
    logic [W-1:0] exp_new [2];
    logic [W-1:0] exp_old [2];

    always #2.5 clk = ~clk;

    edge_stamp_dual #(.CNT_W(W), .DEPTH(DEP), .PRESCALE(PS), .RANGE_TICKS(RNG)) u_edge_stamp_dual (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .sig_in        (sig_in),
        .clr           (clr),
        .rd_path       (rd_path),
        .rd_newest     (rd_newest),
        .rd_older      (rd_older),
        .rd_period     (rd_period),
        .rd_count      (rd_count),
        .rd_valid      (rd_valid),
        .use_prescaled (use_prescaled)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // timebase value the model expects: all ones minus ticks, modulo 2^W (R2)
    function automatic logic [W-1:0] tb_now();
        return W'(255 - (ticks % 256));
    endfunction

    task automatic store(input int p, input logic [W-1:0] s);
        exp_old[p] = exp_new[p];
        exp_new[p] = s;
        if (exp_cnt[p] < DEP) exp_cnt[p]++;
    endtask

    task automatic model_edge();
        logic [W-1:0] s;
        s = tb_now();
        store(0, s);
        pre_edges++;
        if (pre_edges == PS) begin
            pre_edges = 0;
            store(1, s);
        end
    endtask

    task automatic advance(input int n);
        if (n > 0) begin
            @(negedge clk) tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
            ticks += n;
        end
    endtask

    task automatic pulse();
        @(negedge clk) sig_in = 1'b1;
        repeat (8) @(negedge clk);
        model_edge();
        sig_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic verify_all();
        logic [W-1:0] dper;
        for (int p = 0; p < 2; p++) begin
            rd_path = p[0];
            #1;
            if (exp_cnt[p] >= 1)
                check(p == 0 ? "R1/R2 direct newest stamp" : "R7/R11 prescaled newest stamp",
                      rd_newest, exp_new[p]);
            if (exp_cnt[p] >= 2) begin
                check(p == 0 ? "R3 direct previous stamp" : "R3/R11 prescaled previous stamp",
                      rd_older, exp_old[p]);
                check("R4 period", rd_period, W'(exp_old[p] - exp_new[p]));
            end else begin
                check("R4 period zero when not valid", rd_period, 0);
            end
            check(p == 0 ? "R3 direct count" : "R6/R3 prescaled count", rd_count, exp_cnt[p]);
            check("R5 valid", rd_valid, exp_cnt[p] >= 2);
        end
        dper = W'(exp_old[0] - exp_new[0]);
        check("R8 range select", use_prescaled, (exp_cnt[0] >= 2) && (dper < RNG));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_cnt[0] = 0; exp_cnt[1] = 0;
        exp_new[0] = '0; exp_new[1] = '0;
        exp_old[0] = '0; exp_old[1] = '0;

        // reset state with input already high (R10)
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        verify_all();

        // falling edge is not stamped (R10)
        sig_in = 1'b0;
        repeat (10) @(negedge clk);
        verify_all();

        // first sweep: spacings across the range threshold, wrapping the timebase
        for (int i = 0; i < 30; i++) begin
            advance(200 + i);
            pulse();
            verify_all();
        end

        // second sweep: zero to aliasing spacings
        for (int i = 0; i < 25; i++) begin
            advance(i * 11);
            pulse();
            verify_all();
        end

        // clear: rings empty, prescaler restarts, timebase untouched (R9)
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        exp_cnt[0] = 0; exp_cnt[1] = 0; pre_edges = 0;
        verify_all();
        for (int i = 0; i < PS; i++) begin
            advance(17 + i);
            pulse();
            verify_all();   // prescaled count stays 0 until the fourth edge (R6)
        end

        // long high level gives one stamp only (R10)
        @(negedge clk) sig_in = 1'b1;
        repeat (8) @(negedge clk);
        model_edge();
        advance(50);
        repeat (8) @(negedge clk);
        verify_all();
        sig_in = 1'b0;
        repeat (8) @(negedge clk);
        verify_all();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule